// File: doc/BRIEF.md
# Power-Good Reset and Suspend Control

This block turns a power-good input and a battery-domain reset input into the chip's power-up resets. When power-good rises, the system reset and the CPU reset are held active for a fixed number of clocks. While power-good is low, their pin drivers are switched off and external pull-ups hold the lines high. A third output, the peripheral-core reset, follows the same interval unless a retained suspend-inhibit bit was set before the power-up. This lets a suspend-to-disk resume keep the peripheral state while the CPU still gets a full reset.

The inhibit bit and a battery-valid flag sit in the always-powered domain. The inhibit bit is cleared asynchronously, and only when power-good and the battery reset input are low together. The battery-valid flag is cleared when the battery reset input is seen low while power is off. While power is good, the battery reset input has no effect, so a slow RC network on that pin cannot upset a running system. A clear level for the registers that are not preserved, and a one-cycle strobe for latching a strap pin at the end of system reset, complete the block.

Top module: `pwrgood_rst_ctrl`

## Requirements
- R1: After the synchronized power-good goes high, `sys_rst` and `cpu_rst` stay 1 for exactly `HOLD_CYCLES` clocks and then go to 0. This holds whatever the value of the inhibit bit.
- R2: While the synchronized power-good is low, `sys_rst_oe` and `cpu_rst_oe` are 0, and `sys_rst` and `cpu_rst` read 1.
- R3: `core_rst` equals `sys_rst` when the inhibit bit was 0 at the moment power-good came up. It stays 0 throughout a power-up that began with the inhibit bit at 1.
- R4: The inhibit bit (`cfg_inh_rd`) is cleared as soon as the raw `pwr_ok` and the raw `bat_rst_n` are both low. In every other case it keeps its value, including while power is off.
- R5: While the synchronized power-good is high, `bat_rst_n` has no effect on `bat_ok` or on the inhibit bit.
- R6: If the synchronized `bat_rst_n` is low while the synchronized power-good is low, `bat_ok` goes to 0 on the next clock.
- R7: A write is made by holding `cfg_we` high for one clock. While power is good, it loads `cfg_inh_d` into the inhibit bit and sets `bat_ok` when `cfg_ok_set` is 1. While power is off, the write changes nothing.
- R8: `strap_latch` is 1 for exactly one clock: the first clock in which `sys_rst` is 0 after a power-up.
- R9: `cfg_clr` is 1 exactly while the synchronized power-good is low.
- R10: `pwr_ok` and `bat_rst_n` each pass through two flops before use, so a rising edge of `pwr_ok` first enables the reset drivers on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok | input | 1 | Power-good, asynchronous |
| bat_rst_n | input | 1 | Battery-domain reset, active low, asynchronous |
| cfg_we | input | 1 | Write strobe for the retained bits |
| cfg_inh_d | input | 1 | New value of the inhibit bit |
| cfg_ok_set | input | 1 | Writing 1 sets the battery-valid flag |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_oe | output | 1 | Driver enable for the system reset pin |
| cpu_rst | output | 1 | CPU reset, active high |
| cpu_rst_oe | output | 1 | Driver enable for the CPU reset pin |
| core_rst | output | 1 | Peripheral-core reset, active high |
| strap_latch | output | 1 | One-cycle strobe that latches the strap pin |
| cfg_clr | output | 1 | Clear level for the registers that are not preserved |
| cfg_inh_rd | output | 1 | Read-back of the inhibit bit |
| bat_ok | output | 1 | Battery-valid status flag |

## Verification
Two faults show up at the ports at very different times:
- A miscounting timer moves the falling edge of `sys_rst`. It also moves the `strap_latch` strobe. This is visible within one clock of the expected edge.
- A wrong retained bit, or a wrong latched copy of it, is invisible while power is off. It appears only at the next power-up: `core_rst` is asserted or held back for the whole interval.

The bench therefore runs several power cycles with the inhibit bit at both values. It compares every output with a behavioural model on each clock, and it pulses `bat_rst_n` both with power on and with power off.

// File: rtl/pwrgood_rst_ctrl.sv
module pwrgood_rst_ctrl #(
  parameter int HOLD_CYCLES = 8325000
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic bat_rst_n,
  input  logic cfg_we,
  input  logic cfg_inh_d,
  input  logic cfg_ok_set,
  output logic sys_rst,
  output logic sys_rst_oe,
  output logic cpu_rst,
  output logic cpu_rst_oe,
  output logic core_rst,
  output logic strap_latch,
  output logic cfg_clr,
  output logic cfg_inh_rd,
  output logic bat_ok
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES);

  logic [1:0] pg_ff, br_ff;
  logic pg_s, br_s;
  logic [CW-1:0] cnt;
  logic busy, busy_d, inh, inh_lat, ok, clr_async;

  always_ff @(posedge clk) begin
    pg_ff <= {pg_ff[0], pwr_ok};
    br_ff <= {br_ff[0], bat_rst_n};
  end
  assign pg_s = pg_ff[1];
  assign br_s = br_ff[1];

  always_ff @(posedge clk) begin
    if (!pg_s) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end
  assign busy = (cnt != LAST);

  always_ff @(posedge clk) begin
    busy_d <= busy;
    if (!pg_s) inh_lat <= inh;
  end

  assign clr_async = ~pwr_ok & ~bat_rst_n;

  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async) inh <= 1'b0;
    else if (pg_s && cfg_we) inh <= cfg_inh_d;
  end

  always_ff @(posedge clk) begin
    if (!pg_s && !br_s) ok <= 1'b0;
    else if (pg_s && cfg_we && cfg_ok_set) ok <= 1'b1;
  end

  assign sys_rst     = ~pg_s | busy;
  assign cpu_rst     = sys_rst;
  assign sys_rst_oe  = pg_s;
  assign cpu_rst_oe  = pg_s;
  assign core_rst    = sys_rst & ~inh_lat;
  assign strap_latch = pg_s & busy_d & ~busy;
  assign cfg_clr     = ~pg_s;
  assign cfg_inh_rd  = inh;
  assign bat_ok      = ok;
endmodule

module pwrgood_rst_ctrl_chk (
  input logic clk,
  input logic pwr_ok,
  input logic bat_rst_n,
  input logic cfg_we,
  input logic pg_s,
  input logic br_s,
  input logic sys_rst,
  input logic sys_rst_oe,
  input logic cpu_rst,
  input logic cpu_rst_oe,
  input logic core_rst,
  input logic strap_latch,
  input logic cfg_clr,
  input logic cfg_inh_rd,
  input logic bat_ok
);
  logic [1:0] age = 2'd0;
  logic live;
  always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;
  assign live = (age == 2'd3);

  a_r1_same_rst: assert property (@(posedge clk) disable iff (!live)
    sys_rst == cpu_rst);
  a_r2_oe_pair: assert property (@(posedge clk) disable iff (!live)
    !sys_rst_oe |-> (!cpu_rst_oe && sys_rst && cpu_rst));
  a_r3_core_within_sys: assert property (@(posedge clk) disable iff (!live)
    (sys_rst_oe && core_rst) |-> sys_rst);
  a_r4_inh_clear: assert property (@(posedge clk) disable iff (!live)
    (!pwr_ok && !bat_rst_n) |=> !cfg_inh_rd);
  a_r5_ok_hold: assert property (@(posedge clk) disable iff (!live)
    (pg_s && !cfg_we) |=> $stable(bat_ok));
  a_r6_ok_clear: assert property (@(posedge clk) disable iff (!live)
    (!pg_s && !br_s) |=> !bat_ok);
  a_r8_strap_edge: assert property (@(posedge clk) disable iff (!live)
    strap_latch |-> ($past(sys_rst) && !sys_rst));
  a_r9_clr_level: assert property (@(posedge clk) disable iff (!live)
    cfg_clr |-> !sys_rst_oe);
endmodule

bind pwrgood_rst_ctrl pwrgood_rst_ctrl_chk u_chk (
  .clk(clk), .pwr_ok(pwr_ok), .bat_rst_n(bat_rst_n), .cfg_we(cfg_we),
  .pg_s(pg_s), .br_s(br_s), .sys_rst(sys_rst), .sys_rst_oe(sys_rst_oe),
  .cpu_rst(cpu_rst), .cpu_rst_oe(cpu_rst_oe), .core_rst(core_rst),
  .strap_latch(strap_latch), .cfg_clr(cfg_clr), .cfg_inh_rd(cfg_inh_rd),
  .bat_ok(bat_ok)
);

// File: tb/sim_pwrgood_rst_ctrl.sv
module sim_pwrgood_rst_ctrl;
  localparam int HOLD = 20;
  logic clk = 1'b0;
  logic pwr_ok = 1'b0, bat_rst_n = 1'b0, cfg_we = 1'b0, cfg_inh_d = 1'b0, cfg_ok_set = 1'b0;
  logic sys_rst, sys_rst_oe, cpu_rst, cpu_rst_oe, core_rst, strap_latch, cfg_clr, cfg_inh_rd, bat_ok;
  int checks = 0, fails = 0, cycles = 0;
  bit armed = 0;

  always #5 clk = ~clk;

  pwrgood_rst_ctrl #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .pwr_ok(pwr_ok), .bat_rst_n(bat_rst_n), .cfg_we(cfg_we),
    .cfg_inh_d(cfg_inh_d), .cfg_ok_set(cfg_ok_set), .sys_rst(sys_rst),
    .sys_rst_oe(sys_rst_oe), .cpu_rst(cpu_rst), .cpu_rst_oe(cpu_rst_oe),
    .core_rst(core_rst), .strap_latch(strap_latch), .cfg_clr(cfg_clr),
    .cfg_inh_rd(cfg_inh_rd), .bat_ok(bat_ok));

  int pg_hist[$], br_hist[$];
  int m_cnt = 0;
  bit m_inh = 0, m_lat = 0, m_ok = 0, m_prev_busy = 1;

  function automatic bit m_pg(); return pg_hist.size() >= 2 && pg_hist[pg_hist.size()-2] == 1; endfunction
  function automatic bit m_br(); return br_hist.size() >= 2 && br_hist[br_hist.size()-2] == 1; endfunction

  always @(posedge clk) begin
    bit pg, br, busy_now;
    pg = m_pg(); br = m_br();
    busy_now = (m_cnt < HOLD);
    m_prev_busy = busy_now;
    if (!pg) begin
      m_cnt = 0; m_lat = m_inh;
      if (!br) m_ok = 0;
    end else begin
      if (m_cnt < HOLD) m_cnt++;
      if (cfg_we) begin m_inh = cfg_inh_d; if (cfg_ok_set) m_ok = 1; end
    end
    if (!pwr_ok && !bat_rst_n) m_inh = 0;
    pg_hist.push_back(pwr_ok); br_hist.push_back(bat_rst_n);
    if (pg_hist.size() > 4) begin void'(pg_hist.pop_front()); void'(br_hist.pop_front()); end
    cycles++;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    bit pg, busy, s;
    pg = m_pg();
    if (!pwr_ok && !bat_rst_n) m_inh = 0;
    busy = (m_cnt < HOLD);
    s = !pg || busy;
    chk("R1 sys_rst", sys_rst, s);
    chk("R1 cpu_rst", cpu_rst, s);
    chk("R2 sys_rst_oe", sys_rst_oe, pg);
    chk("R2 cpu_rst_oe", cpu_rst_oe, pg);
    chk("R3 core_rst", core_rst, s && !m_lat);
    chk("R4 inhibit", cfg_inh_rd, m_inh);
    chk("R6 bat_ok", bat_ok, m_ok);
    chk("R8 strap_latch", strap_latch, pg && m_prev_busy && !busy);
    chk("R9 cfg_clr", cfg_clr, !pg);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic inh, input logic set);
    cfg_we = 1; cfg_inh_d = inh; cfg_ok_set = set;
    step(1);
    cfg_we = 0; cfg_inh_d = 0; cfg_ok_set = 0;
  endtask

  initial begin
    step(5);
    armed = 1;
    chk("R2 reset state oe", sys_rst_oe, 1'b0);
    chk("R6 reset state bat_ok", bat_ok, 1'b0);
    bat_rst_n = 1; step(2);
    pwr_ok = 1; step(1);
    chk("R10 oe still off one clock after rise", sys_rst_oe, 1'b0);
    step(1);
    chk("R10 oe on after two clocks", sys_rst_oe, 1'b1);
    step(5);
    wr(1, 1);
    chk("R7 inhibit written", cfg_inh_rd, 1'b1);
    chk("R7 bat_ok set", bat_ok, 1'b1);
    step(HOLD);
    bat_rst_n = 0; step(4);
    chk("R5 bat_ok unaffected", bat_ok, 1'b1);
    chk("R5 inhibit unaffected", cfg_inh_rd, 1'b1);
    bat_rst_n = 1; step(2);
    pwr_ok = 0; step(4);
    wr(0, 0);
    chk("R7 write ignored while off", cfg_inh_rd, 1'b1);
    chk("R4 inhibit retained over power loss", cfg_inh_rd, 1'b1);
    step(3);
    pwr_ok = 1; step(HOLD + 6);
    chk("R3 core_rst held off on inhibited power-up", core_rst, 1'b0);
    wr(0, 0);
    pwr_ok = 0; step(3);
    bat_rst_n = 0; step(1);
    chk("R4 inhibit cleared by both low", cfg_inh_rd, 1'b0);
    step(3);
    chk("R6 bat_ok cleared", bat_ok, 1'b0);
    bat_rst_n = 1; step(3);
    pwr_ok = 1; step(3);
    wr(1, 0);
    step(HOLD + 4);
    pwr_ok = 0; step(3);
    pwr_ok = 1; step(4);
    wr(0, 1);
    step(HOLD + 4);
    armed = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule